// File: doc/BRIEF.md
# Modulo-3 Serial Accumulator

This block keeps a running total, modulo 3, of a stream of 2-bit operands, taking one operand on every rising clock edge. The stored residue is held in two D-type state bits. The output is that stored code, shown with no added logic, so the block is a Moore machine. A new operand is folded in at every edge with no enable or strobe.

The next-state logic is a two-level sum-of-products with three product terms per state bit. It uses no adder and no comparator. A build parameter can swap this for an equivalent case table, which gives a second, independently written form of the same function. The unused code 11 has defined handling. As an operand it leaves the stored residue unchanged. As a state it is never entered, and if it ever appears it returns to 00 on the next edge.

Top module: `tri_residue_acc`

## Requirements
- R1: While `rst` is sampled high at a rising edge, the stored residue becomes 00. It stays 00 for as long as `rst` is held high.
- R2: The output shows the stored residue as a binary code: value 0 is 00, value 1 is 01 and value 2 is 10.
- R3: With `rst` low and an operand of 01 or 10, the residue after the edge equals (residue + operand) mod 3.
- R4: With `rst` low and an operand of 00, the residue is unchanged after the edge.
- R5: With `rst` low and an operand of 11, the residue is unchanged after the edge.
- R6: The output never shows the code 11.
- R7: Reset takes priority over the operand. An edge with `rst` high gives 00 whatever the operand is.
- R8: The sum-of-products form (`SOP_FORM` = 1) and the case-table form (`SOP_FORM` = 0) give the same residue on every cycle for the same stimulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opnd_i | input | 2 | Operand added on this edge; 11 is ignored |
| res_o | output | 2 | Stored residue, 00, 01 or 10 |

## Verification
The bench builds two copies of the block from the same stimulus. One uses the default sum-of-products form and the other uses `SOP_FORM` = 0, and the bench compares them on every cycle. This covers R8 and shows that each logic form matches the arithmetic model. The directed tasks walk all nine legal state and operand pairs, apply the ignored operand 11 from each state, and assert reset with a nonzero operand. A long stream of random legal operands then runs against the bench's own mod-3 model.

// File: rtl/tri_residue_pkg.sv
package tri_residue_pkg;

    localparam int RES_W = 2;
    localparam int OPND_W = 2;

    typedef enum logic [RES_W-1:0] {
        RES_ZERO = 2'b00,
        RES_ONE  = 2'b01,
        RES_TWO  = 2'b10,
        RES_BAD  = 2'b11
    } residue_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } code_t;

    localparam logic [OPND_W-1:0] OPND_SKIP = 2'b11;

    // Table form of the step: the row is the current code, the column is the operand.
    function automatic residue_e step_table(residue_e cur, logic [OPND_W-1:0] op);
        residue_e nxt;
        nxt = RES_ZERO;
        unique case (cur)
            RES_ZERO: case (op)
                2'b00:   nxt = RES_ZERO;
                2'b01:   nxt = RES_ONE;
                2'b10:   nxt = RES_TWO;
                default: nxt = RES_ZERO;
            endcase
            RES_ONE: case (op)
                2'b00:   nxt = RES_ONE;
                2'b01:   nxt = RES_TWO;
                2'b10:   nxt = RES_ZERO;
                default: nxt = RES_ONE;
            endcase
            RES_TWO: case (op)
                2'b00:   nxt = RES_TWO;
                2'b01:   nxt = RES_ZERO;
                2'b10:   nxt = RES_ONE;
                default: nxt = RES_TWO;
            endcase
            default: nxt = RES_ZERO;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/tri_residue_next.sv
module tri_residue_next
    import tri_residue_pkg::*;
#(
    parameter bit SOP_FORM = 1'b1
) (
    input  residue_e              cur_i,
    input  logic [OPND_W-1:0]     opnd_i,
    output residue_e              nxt_o
);

    generate
        if (SOP_FORM) begin : g_sop
            code_t y;
            code_t d;
            logic  x1;
            logic  x0;
            logic  bad_state;
            logic  skip_op;

            always_comb begin
                y         = code_t'(cur_i);
                x1        = opnd_i[1];
                x0        = opnd_i[0];
                bad_state = y.hi & y.lo;
                skip_op   = x1 & x0;
                // Three product terms per bit, valid for legal codes.
                d.hi = (y.hi & ~x1 & ~x0) | (y.lo & x0) | (~y.hi & ~y.lo & x1);
                d.lo = (y.lo & ~x1 & ~x0) | (y.hi & x1) | (~y.hi & ~y.lo & x0);
                if (bad_state) begin
                    nxt_o = RES_ZERO;
                end else if (skip_op) begin
                    nxt_o = cur_i;
                end else begin
                    nxt_o = residue_e'(d);
                end
            end
        end else begin : g_tbl
            always_comb begin
                nxt_o = step_table(cur_i, opnd_i);
            end
        end
    endgenerate

endmodule

// File: rtl/tri_residue_reg.sv
module tri_residue_reg
    import tri_residue_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  residue_e d_i,
    output residue_e q_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= RES_ZERO;
        end else begin
            q_o <= d_i;
        end
    end

endmodule

// File: rtl/tri_residue_acc.sv
module tri_residue_acc
    import tri_residue_pkg::*;
#(
    parameter bit SOP_FORM = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OPND_W-1:0] opnd_i,
    output logic [RES_W-1:0]  res_o
);

    residue_e state_q;
    residue_e state_d;

    tri_residue_next #(
        .SOP_FORM (SOP_FORM)
    ) u_next (
        .cur_i  (state_q),
        .opnd_i (opnd_i),
        .nxt_o  (state_d)
    );

    tri_residue_reg u_reg (
        .clk (clk),
        .rst (rst),
        .d_i (state_d),
        .q_o (state_q)
    );

    assign res_o = state_q;

endmodule

// File: rtl/tri_residue_acc_chk.sv
module tri_residue_acc_chk
    import tri_residue_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [OPND_W-1:0] opnd_i,
    input logic [RES_W-1:0]  res_o
);

    // R1, R7: the first cycle after reset shows zero
    p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> res_o == 2'b00);

    // R6: code 11 never appears
    p_legal_code_r6: assert property (@(posedge clk) disable iff (rst)
        res_o != 2'b11);

    // R4: a zero operand holds
    p_hold_zero_r4: assert property (@(posedge clk) disable iff (rst)
        opnd_i == 2'b00 |=> $stable(res_o));

    // R5: operand 11 is ignored
    p_hold_skip_r5: assert property (@(posedge clk) disable iff (rst)
        opnd_i == 2'b11 |=> $stable(res_o));

    // R3: a nonzero legal operand always moves the residue
    p_moves_r3: assert property (@(posedge clk) disable iff (rst)
        (opnd_i == 2'b01 || opnd_i == 2'b10) |=> res_o != $past(res_o));

    // R3: from zero, operand 01 lands on 01
    p_zero_plus_one_r3: assert property (@(posedge clk) disable iff (rst)
        (res_o == 2'b00 && opnd_i == 2'b01) |=> res_o == 2'b01);

endmodule

bind tri_residue_acc tri_residue_acc_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .opnd_i (opnd_i),
    .res_o  (res_o)
);

// File: tb/tri_residue_acc_bench.sv
`timescale 1ns/1ps
module tri_residue_acc_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] opnd = 2'b00;
    logic [1:0] res_sop;
    logic [1:0] res_tbl;

    int checks = 0;
    int errors = 0;
    int model  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    tri_residue_acc u_tri_residue_acc (
        .clk (clk), .rst (rst), .opnd_i (opnd), .res_o (res_sop)
    );

    tri_residue_acc #(.SOP_FORM(1'b0)) u_tri_residue_acc_tbl (
        .clk (clk), .rst (rst), .opnd_i (opnd), .res_o (res_tbl)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One edge: drive at the falling edge, sample 1 ns after the rising edge.
    task automatic step(input logic [1:0] op, input logic r, input string req);
        @(negedge clk);
        opnd = op;
        rst  = r;
        @(posedge clk);
        #1;
        if (r) model = 0;
        else if (op != 2'b11) model = (model + op) % 3;
        check(res_sop == model[1:0], req, res_sop, model);
        check(res_tbl == res_sop, "R8", res_tbl, res_sop);
        check(res_sop != 2'b11, "R6", res_sop, model);
    endtask

    task automatic go_to(input int v);
        step(2'b00, 1'b1, "R1");
        if (v != 0) step(v[1:0], 1'b0, "R3");
    endtask

    task automatic t_reset();
        step(2'b00, 1'b1, "R1");
        step(2'b01, 1'b1, "R1");
        check(res_sop == 2'b00, "R1", res_sop, 0);
    endtask

    task automatic t_all_pairs();
        for (int s = 0; s < 3; s++) begin
            for (int o = 0; o < 3; o++) begin
                go_to(s);
                step(o[1:0], 1'b0, (o == 0) ? "R4" : "R3");
                check(res_sop == ((s + o) % 3), "R2", res_sop, (s + o) % 3);
            end
        end
    endtask

    task automatic t_skip_operand();
        for (int s = 0; s < 3; s++) begin
            go_to(s);
            step(2'b11, 1'b0, "R5");
            step(2'b11, 1'b0, "R5");
            check(res_sop == s[1:0], "R5", res_sop, s);
        end
    endtask

    task automatic t_reset_priority();
        go_to(2);
        step(2'b01, 1'b1, "R7");
        check(res_sop == 2'b00, "R7", res_sop, 0);
        go_to(1);
        step(2'b10, 1'b1, "R7");
    endtask

    task automatic t_random_stream();
        step(2'b00, 1'b1, "R1");
        for (int i = 0; i < 2000; i++) begin
            step(2'($urandom_range(0, 2)), 1'b0, "R3");
        end
    endtask

    initial begin
        step(2'b00, 1'b1, "R1");
        t_reset();
        t_all_pairs();
        t_skip_operand();
        t_reset_priority();
        t_random_stream();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule